// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric and turns two I/O port locations into configuration cycles. One location holds a 32-bit address latch. The other is a four-byte data window. Software writes a target descriptor into the latch: an enable flag, a bus number, a device/function number and a register offset. It then reads or writes the window to reach a function's configuration registers. Accesses to the window may be 8, 16 or 32 bits wide.

On a data-window access the bridge performs several checks. It tests the enable flag, compares the bus number with its own, and looks up the device/function in a presence vector. If every check passes, it issues one request on the downstream configuration interface. A read then waits for the target's data, masks it to the access width and returns it to the I/O side. If any check fails, nothing is issued downstream. A read then answers with all-ones sized to the access, and a write is dropped.

The register offset is formed in one of two ways. For a 32-bit access it is the latched offset with its two low bits cleared. For a narrower access it is the latched offset with the window's byte offset ORed in.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, io_ack and cfg_req are low and a read of the address port returns 0.
- R2: With io_sel=0 (address port), a write stores io_wdata into the 32-bit latch and a read returns the last stored value. Both acknowledge with io_ack one cycle after the request is sampled.
- R3: With io_sel=1 (data window) and latch bit 31 clear, a read returns all-ones of the access size and a write issues no cfg_req.
- R4: A latch bus field (bits 23:16) that differs from parameter OWN_BUS makes a data read return all-ones and a data write issue no cfg_req.
- R5: A device/function (latch bits 15:8) whose bit in `present` is 0 makes a data read return all-ones and a data write issue no cfg_req.
- R6: A 32-bit data access (io_size=2) drives cfg_reg as latch bits 7:0 with bits 1:0 forced to 0.
- R7: An 8- or 16-bit data access drives cfg_reg as latch bits 7:0 ORed with io_off.
- R8: A data read to a present target raises cfg_req for one cycle with cfg_wr=0. io_ack follows one cycle after cfg_rvalid is sampled, with cfg_rdata masked to the access width.
- R9: A data write to a present target raises cfg_req with cfg_wr=1 and cfg_wdata=io_wdata. io_ack rises in the same cycle.
- R10: Size codes are 0=byte, 1=halfword, 2 or 3=word. A missed read acknowledges one cycle after the request with 0x000000FF, 0x0000FFFF or 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O access request, one cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_sel | input | 1 | 0 = address port, 1 = data window |
| io_off | input | 2 | Byte offset within the data window |
| io_size | input | 2 | Access size code |
| io_wdata | input | 32 | Write data, right-aligned |
| io_ack | output | 1 | Access complete |
| io_rdata | output | 32 | Read data, valid with io_ack |
| present | input | 256 | One bit per device/function, 1 = responds |
| cfg_req | output | 1 | Configuration request strobe |
| cfg_wr | output | 1 | Configuration write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 8 | Register offset |
| cfg_size | output | 2 | Access size code |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rvalid | input | 1 | Read data valid from target |
| cfg_rdata | input | 32 | Read data from target |

## Verification
The hardest case to reach is the narrow access whose window offset overlaps bits already set in the latched offset. That is the only case in which ORing and adding give different register numbers. The stimulus latches an odd offset and then reads one byte at a nonzero window offset. It also latches an offset with set low bits and makes a word access, to show that those bits are cleared. The misses are reached separately by changing one latch field at a time: the enable flag, then the bus, then the device/function.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter logic [7:0] OWN_BUS = 8'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic        io_sel,
  input  logic [1:0]  io_off,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic        io_ack,
  output logic [31:0] io_rdata,
  input  logic [255:0] present,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [7:0]  cfg_bus,
  output logic [7:0]  cfg_devfn,
  output logic [7:0]  cfg_reg,
  output logic [1:0]  cfg_size,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rvalid,
  input  logic [31:0] cfg_rdata
);
  logic [31:0] addr_q;
  logic        waiting;
  logic [1:0]  rd_size;

  logic        en_bit, bus_ok, fn_ok, hit;
  logic [7:0]  reg_sel;
  logic [31:0] req_ones;

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  assign en_bit   = addr_q[31];
  assign bus_ok   = addr_q[23:16] == OWN_BUS;
  assign fn_ok    = present[addr_q[15:8]];
  assign hit      = en_bit && bus_ok && fn_ok;
  assign reg_sel  = io_size[1] ? {addr_q[7:2], 2'b00} : (addr_q[7:0] | {6'd0, io_off});
  assign req_ones = width_mask(io_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      waiting   <= 1'b0;
      rd_size   <= 2'd0;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_wr    <= 1'b0;
      cfg_bus   <= '0;
      cfg_devfn <= '0;
      cfg_reg   <= '0;
      cfg_size  <= '0;
      cfg_wdata <= '0;
    end else begin
      io_ack  <= 1'b0;
      cfg_req <= 1'b0;
      if (waiting) begin
        if (cfg_rvalid) begin
          waiting  <= 1'b0;
          io_ack   <= 1'b1;
          io_rdata <= cfg_rdata & width_mask(rd_size);
        end
      end else if (io_req) begin
        if (!io_sel) begin
          io_ack <= 1'b1;
          if (io_wr) begin
            addr_q   <= io_wdata;
            io_rdata <= '0;
          end else begin
            io_rdata <= addr_q;
          end
        end else if (hit) begin
          cfg_req   <= 1'b1;
          cfg_wr    <= io_wr;
          cfg_bus   <= addr_q[23:16];
          cfg_devfn <= addr_q[15:8];
          cfg_reg   <= reg_sel;
          cfg_size  <= io_size;
          cfg_wdata <= io_wdata;
          rd_size   <= io_size;
          if (io_wr) begin
            io_ack   <= 1'b1;
            io_rdata <= '0;
          end else begin
            waiting <= 1'b1;
          end
        end else begin
          io_ack   <= 1'b1;
          io_rdata <= io_wr ? 32'd0 : req_ones;
        end
      end
    end
  end
endmodule

module cfg_port_bridge_chk #(
  parameter logic [7:0] OWN_BUS = 8'd0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_req,
  input logic [7:0]   cfg_bus,
  input logic [7:0]   cfg_devfn,
  input logic [7:0]   cfg_reg,
  input logic [1:0]   cfg_size,
  input logic [255:0] present,
  input logic [31:0]  addr_q
);
  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> addr_q[31]);
  // R4
  bus_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_bus == OWN_BUS);
  // R5
  fn_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> present[cfg_devfn]);
  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_size[1]) |-> cfg_reg[1:0] == 2'b00);
  // R7
  narrow_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_size[1]) |-> cfg_reg[7:2] == addr_q[7:2]);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.OWN_BUS(OWN_BUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_bus(cfg_bus),
  .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_size(cfg_size),
  .present(present), .addr_q(addr_q)
);

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req = 0, io_wr = 0, io_sel = 0;
  logic [1:0] io_off = 0, io_size = 0;
  logic [31:0] io_wdata = 0;
  logic io_ack;
  logic [31:0] io_rdata;
  logic [255:0] present;
  logic cfg_req, cfg_wr;
  logic [7:0] cfg_bus, cfg_devfn, cfg_reg;
  logic [1:0] cfg_size;
  logic [31:0] cfg_wdata;
  logic cfg_rvalid;
  logic [31:0] cfg_rdata;

  always #5 clk = ~clk;

  cfg_port_bridge #(.OWN_BUS(8'h02)) u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_sel(io_sel),
    .io_off(io_off), .io_size(io_size), .io_wdata(io_wdata), .io_ack(io_ack),
    .io_rdata(io_rdata), .present(present), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
    .cfg_rdata(cfg_rdata)
  );

  integer n_vec = 0, n_bad = 0, n_cfg = 0;
  logic [7:0] l_bus, l_fn, l_reg;
  logic [1:0] l_size;
  logic l_wr;
  logic [31:0] l_wdata;
  logic [1:0] pipe = 2'b00;
  logic [31:0] rsp_hold = 0;

  function automatic logic [31:0] rsp_word(input logic [7:0] fn, input logic [7:0] rg);
    return {fn, rg, 8'h5A, rg ^ 8'hC3};
  endfunction
  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (cfg_req) begin
      n_cfg   <= n_cfg + 1;
      l_bus   <= cfg_bus;   l_fn <= cfg_devfn; l_reg <= cfg_reg;
      l_size  <= cfg_size;  l_wr <= cfg_wr;    l_wdata <= cfg_wdata;
      if (!cfg_wr) rsp_hold <= rsp_word(cfg_devfn, cfg_reg);
    end
    pipe <= {pipe[0], cfg_req & ~cfg_wr};
  end
  assign cfg_rvalid = pipe[1];
  assign cfg_rdata  = pipe[1] ? rsp_hold : 32'hDEAD_BEEF;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic s, input logic w, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output integer lat);
    @(negedge clk);
    io_req = 1; io_sel = s; io_wr = w; io_off = off; io_size = sz; io_wdata = wd;
    lat = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      io_req = 0;
      lat++;
      if (io_ack) break;
    end
    rd = io_rdata;
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [31:0] a);
    logic [31:0] rd; integer lat;
    xfer(1'b0, 1'b1, 2'd0, 2'd2, a, rd, lat);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; integer lat, c0;
    present = '0;
    present[8'h00] = 1'b1; present[8'h08] = 1'b1; present[8'h10] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({31'd0, io_ack}, 0, "R1 io_ack idle");
    chk({31'd0, cfg_req}, 0, "R1 cfg_req idle");
    xfer(1'b0, 1'b0, 2'd0, 2'd2, 0, rd, lat);
    chk(rd, 0, "R1 address after reset");

    xfer(1'b0, 1'b1, 2'd0, 2'd2, 32'h1234_5678, rd, lat);
    chk(lat, 1, "R2 write ack latency");
    xfer(1'b0, 1'b0, 2'd0, 2'd2, 0, rd, lat);
    chk(rd, 32'h1234_5678, "R2 readback");
    chk(lat, 1, "R2 read ack latency");

    set_addr(32'h0002_0810);
    for (int s = 0; s < 3; s++) begin
      xfer(1'b1, 1'b0, 2'd0, 2'(s), 0, rd, lat);
      chk(rd, ones_of(2'(s)), "R3 R10 disabled read");
      chk(lat, 1, "R10 miss latency");
    end
    c0 = n_cfg;
    xfer(1'b1, 1'b1, 2'd0, 2'd2, 32'hCAFE_0001, rd, lat);
    chk(n_cfg - c0, 0, "R3 disabled write dropped");

    set_addr(32'h8003_0810);
    xfer(1'b1, 1'b0, 2'd1, 2'd0, 0, rd, lat);
    chk(rd, 32'hFF, "R4 R10 bus mismatch byte");
    c0 = n_cfg;
    xfer(1'b1, 1'b1, 2'd0, 2'd2, 32'hCAFE_0002, rd, lat);
    chk(n_cfg - c0, 0, "R4 write dropped");

    set_addr(32'h8002_0910);
    xfer(1'b1, 1'b0, 2'd2, 2'd1, 0, rd, lat);
    chk(rd, 32'hFFFF, "R5 R10 absent halfword");
    c0 = n_cfg;
    xfer(1'b1, 1'b1, 2'd0, 2'd2, 32'hCAFE_0003, rd, lat);
    chk(n_cfg - c0, 0, "R5 write dropped");

    set_addr(32'h8002_0813);
    c0 = n_cfg;
    xfer(1'b1, 1'b0, 2'd2, 2'd2, 0, rd, lat);
    chk(n_cfg - c0, 1, "R8 one request");
    chk(l_reg, 8'h10, "R6 word aligned reg");
    chk({l_bus, l_fn}, 16'h0208, "R8 bus devfn");
    chk({31'd0, l_wr}, 0, "R8 read direction");
    chk(rd, rsp_word(8'h08, 8'h10), "R8 word data");
    chk(lat, 4, "R8 ack after rvalid");

    set_addr(32'h8002_1043);
    xfer(1'b1, 1'b0, 2'd1, 2'd0, 0, rd, lat);
    chk(l_reg, 8'h43, "R7 OR not add");
    chk(rd, rsp_word(8'h10, 8'h43) & 32'hFF, "R8 byte mask");

    set_addr(32'h8002_0040);
    xfer(1'b1, 1'b0, 2'd2, 2'd1, 0, rd, lat);
    chk(l_reg, 8'h42, "R7 halfword offset");
    chk({30'd0, l_size}, 1, "R7 size forwarded");
    chk(rd, rsp_word(8'h00, 8'h42) & 32'hFFFF, "R8 halfword mask");

    set_addr(32'h8002_0806);
    c0 = n_cfg;
    xfer(1'b1, 1'b1, 2'd3, 2'd2, 32'hA5A5_1234, rd, lat);
    chk(n_cfg - c0, 1, "R9 write issued");
    chk({31'd0, l_wr}, 1, "R9 write direction");
    chk(l_wdata, 32'hA5A5_1234, "R9 write data");
    chk(l_reg, 8'h04, "R6 write aligned");
    chk(lat, 1, "R9 ack with request");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule